// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several operating modes, together with the current status word and one saved status word for each exception mode. A logical register index from the instruction path is mapped to a physical storage slot by the mode held in the low five bits of the current status word. The mapping differs between register groups. The low eight registers and the program counter are never duplicated. Registers 8 to 12 have a second copy that only fast-interrupt mode uses. Registers 13 and 14 have a private pair for each exception mode.

The surrounding core reads two operands at a time by logical index. It writes one result per cycle. It updates the status words through dedicated write ports. The block also reports whether the current mode is privileged and whether it is an exception mode. Decode, arithmetic, exception entry and the choice of mode belong to the surrounding core.

Top module: `mrf_banked_regfile`

## Requirements
- R1: Logical registers 0 to 7 map to one physical copy in every mode. A value written in one mode reads back unchanged in all other modes.
- R2: Logical registers 8 to 12 use a private copy only when the mode field is 5'h11 (fast interrupt). Every other mode value uses one shared normal copy.
- R3: Logical registers 13 and 14 have a private copy for each of the mode values 5'h11, 5'h12, 5'h13, 5'h17 and 5'h1B. The values 5'h10 (user) and 5'h1F (system) use the normal copy, and so does any unlisted value.
- R4: Logical register 15 is one physical register in all modes.
- R5: There is one saved status word for each of the five exception mode values. In any other mode, `spsr_q` reads zero and a write through `spsr_wr_en` changes no stored word.
- R6: The mode is `cpsr_q[4:0]`. `privileged` is 1 exactly when the mode is not 5'h10.
- R7: `exc_mode` is 1 exactly when `privileged` is 1 and the mode is not 5'h1F.
- R8: Both read ports are combinational. Writes take effect at the rising clock edge. A read of the register being written in the same cycle returns the old value.
- R9: A current-status write takes effect at the next edge. The mapping for a register write in the same cycle uses the old mode. From the next cycle on, reads map with the new mode.
- R10: A synchronous active-low reset clears every register and saved status word to zero and sets `cpsr_q` to 32'h0000_0013 (supervisor).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Register write data |
| cpsr_wr_en | input | 1 | Current status write enable |
| cpsr_wr_data | input | 32 | New current status word |
| cpsr_q | output | 32 | Current status word; bits 4:0 are the mode |
| spsr_wr_en | input | 1 | Saved status write enable for the current mode |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_q | output | 32 | Saved status word of the current mode, or zero |
| privileged | output | 1 | Mode is not user |
| exc_mode | output | 1 | Mode is privileged and not system |

## Verification
A wrong mapping does not show in the cycle of the bad write. It shows only when a later read in another mode returns a value that belongs to a different bank. For this reason the bench fills every logical register in every mode first, then sweeps all of them again in every mode. A stale mode register or a missed status write shows in the first read after the edge. The immediate check after the same-cycle status and register write covers that case.

// File: rtl/mrf_pkg.sv
// Package: shared constants and types for the mode-banked register file.
// Assumes a 16-entry logical register space and 5-bit mode codes.
package mrf_pkg;
    localparam int DATA_W      = 32;
    localparam int LIDX_W      = 4;
    localparam int MODE_W      = 5;
    localparam int N_LO        = 8;          // shared low registers
    localparam int N_HI        = 5;          // registers 8..12
    localparam int N_EXC       = 5;          // exception modes with private copies
    localparam int SLOT_W      = 3;

    // Physical layout bases
    localparam int BASE_HI_NRM = N_LO;
    localparam int BASE_HI_FIQ = BASE_HI_NRM + N_HI;
    localparam int BASE_SL_NRM = BASE_HI_FIQ + N_HI;
    localparam int BASE_SL_EXC = BASE_SL_NRM + 2;
    localparam int PHYS_PC     = BASE_SL_EXC + 2 * N_EXC;
    localparam int N_PHYS      = PHYS_PC + 1;
    localparam int PHYS_W      = $clog2(N_PHYS);

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    typedef struct packed {
        logic              fiq_hi;     // use fast-interrupt copy of 8..12
        logic              exc_valid;  // mode owns private 13/14 and saved status
        logic [SLOT_W-1:0] slot;       // exception slot 0..4
    } bank_sel_t;
endpackage

// File: rtl/mrf_mode_decode.sv
// Module: decodes the 5-bit mode into bank selection and mode flags.
// Assumes unlisted codes bank like user mode.
module mrf_mode_decode
    import mrf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output bank_sel_t         sel,
    output logic              privileged,
    output logic              exc_mode
);
    // Purpose: map the mode code to its exception slot.
    always_comb begin
        sel = '0;
        unique case (mode)
            MODE_FIQ: begin sel.exc_valid = 1'b1; sel.slot = 3'd0; sel.fiq_hi = 1'b1; end
            MODE_IRQ: begin sel.exc_valid = 1'b1; sel.slot = 3'd1; end
            MODE_SVC: begin sel.exc_valid = 1'b1; sel.slot = 3'd2; end
            MODE_ABT: begin sel.exc_valid = 1'b1; sel.slot = 3'd3; end
            MODE_UND: begin sel.exc_valid = 1'b1; sel.slot = 3'd4; end
            default:  sel = '0;
        endcase
    end

    assign privileged = (mode != MODE_USR);
    assign exc_mode   = privileged && (mode != MODE_SYS);
endmodule

// File: rtl/mrf_index_map.sv
// Module: maps a logical register index to a physical slot for a bank selection.
// Assumes the physical layout defined in mrf_pkg.
module mrf_index_map
    import mrf_pkg::*;
(
    input  logic [LIDX_W-1:0] lidx,
    input  bank_sel_t         sel,
    output logic [PHYS_W-1:0] pidx
);
    // Purpose: select the physical slot by register group.
    always_comb begin
        if (int'(lidx) < N_LO) begin
            pidx = PHYS_W'(lidx);
        end else if (int'(lidx) < N_LO + N_HI) begin
            pidx = sel.fiq_hi ? PHYS_W'(BASE_HI_FIQ + int'(lidx) - N_LO)
                              : PHYS_W'(BASE_HI_NRM + int'(lidx) - N_LO);
        end else if (lidx == 4'd15) begin
            pidx = PHYS_W'(PHYS_PC);
        end else begin
            pidx = sel.exc_valid
                 ? PHYS_W'(BASE_SL_EXC + 2 * int'(sel.slot) + int'(lidx) - 13)
                 : PHYS_W'(BASE_SL_NRM + int'(lidx) - 13);
        end
    end
endmodule

// File: rtl/mrf_store.sv
// Module: physical register storage with one write port and RD_PORTS read ports.
// Assumes reads are combinational and writes occur at the rising edge.
module mrf_store
    import mrf_pkg::*;
#(
    parameter int RD_PORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PHYS_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PHYS_W-1:0] raddr [RD_PORTS],
    output logic [DATA_W-1:0] rdata [RD_PORTS]
);
    logic [DATA_W-1:0] mem [N_PHYS];

    // Purpose: clear on reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PHYS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/mrf_banked_regfile.sv
// Module: top of the mode-banked register file with status words.
// Assumes the mode is cpsr_q[4:0]; writes in a cycle use the mode held before it.
module mrf_banked_regfile
    import mrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx,
    output logic [31:0]       rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [31:0]       rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [31:0]       wr_data,
    input  logic              cpsr_wr_en,
    input  logic [31:0]       cpsr_wr_data,
    output logic [31:0]       cpsr_q,
    input  logic              spsr_wr_en,
    input  logic [31:0]       spsr_wr_data,
    output logic [31:0]       spsr_q,
    output logic              privileged,
    output logic              exc_mode
);
    localparam int RD_PORTS = 2;

    bank_sel_t         sel;
    logic [PHYS_W-1:0] raddr [RD_PORTS];
    logic [DATA_W-1:0] rdata [RD_PORTS];
    logic [LIDX_W-1:0] ridx  [RD_PORTS];
    logic [PHYS_W-1:0] waddr;
    logic [DATA_W-1:0] spsr_mem [N_EXC];

    // Purpose: hold the current status word, reset to supervisor mode.
    always_ff @(posedge clk) begin
        if (!rst_n)          cpsr_q <= {{(DATA_W-MODE_W){1'b0}}, MODE_SVC};
        else if (cpsr_wr_en) cpsr_q <= cpsr_wr_data;
    end

    mrf_mode_decode u_dec (
        .mode       (cpsr_q[MODE_W-1:0]),
        .sel        (sel),
        .privileged (privileged),
        .exc_mode   (exc_mode)
    );

    assign ridx[0] = rd_a_idx;
    assign ridx[1] = rd_b_idx;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rmap
        mrf_index_map u_rmap (.lidx(ridx[p]), .sel(sel), .pidx(raddr[p]));
    end

    mrf_index_map u_wmap (.lidx(wr_idx), .sel(sel), .pidx(waddr));

    mrf_store #(.RD_PORTS(RD_PORTS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign rd_a_data = rdata[0];
    assign rd_b_data = rdata[1];

    // Purpose: saved status words, written only in an exception mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_EXC; i++) spsr_mem[i] <= '0;
        end else if (spsr_wr_en && sel.exc_valid) begin
            spsr_mem[sel.slot] <= spsr_wr_data;
        end
    end

    assign spsr_q = sel.exc_valid ? spsr_mem[sel.slot] : '0;
endmodule

// File: rtl/mrf_checker.sv
// Module: assertion checker bound to mrf_banked_regfile.
// Assumes it observes only top-level ports.
module mrf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  rd_a_idx,
    input logic [31:0] rd_a_data,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic [31:0] wr_data,
    input logic        cpsr_wr_en,
    input logic [31:0] cpsr_wr_data,
    input logic [31:0] cpsr_q,
    input logic [31:0] spsr_q,
    input logic        privileged,
    input logic        exc_mode
);
    logic user_like;
    assign user_like = !(cpsr_q[4:0] inside {5'h11, 5'h12, 5'h13, 5'h17, 5'h1B});

    assert_reset_state_R10: assert property (@(posedge clk)
        !rst_n |=> (cpsr_q == 32'h13));

    assert_cpsr_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_wr_en |=> (cpsr_q == $past(cpsr_wr_data)));

    assert_spsr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        user_like |-> (spsr_q == 32'h0));

    assert_exc_implies_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_mode |-> privileged);

    assert_user_unpriv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_q[4:0] == 5'h10) |-> !privileged);

    assert_shared_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < 4'd8) |=>
        ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data))));

    assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !cpsr_wr_en) |=>
        ((rd_a_idx != $past(rd_a_idx)) || (rd_a_data == $past(rd_a_data))));
endmodule

bind mrf_banked_regfile mrf_checker chk_i (.*);

// File: tb/mrf_banked_regfile_tb_top.sv
module mrf_banked_regfile_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, cpsr_q, spsr_q;
    logic        wr_en = 1'b0, cpsr_wr_en = 1'b0, spsr_wr_en = 1'b0;
    logic [31:0] wr_data = '0, cpsr_wr_data = '0, spsr_wr_data = '0;
    logic        privileged, exc_mode;

    int checks = 0;
    int errors = 0;

    // Reference model by register group
    logic [31:0] m_lo [8];
    logic [31:0] m_hi_n [5];
    logic [31:0] m_hi_f [5];
    logic [31:0] m_sl [6][2];   // row 0 normal, rows 1..5 exception slots
    logic [31:0] m_pc;
    logic [31:0] m_spsr [5];
    logic [4:0]  m_mode;

    logic [4:0] modes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};

    always #(CLK_PERIOD/2) clk = ~clk;

    mrf_banked_regfile dut_i (.*);

    function automatic int slot_of(input logic [4:0] m);
        case (m)
            5'h11: return 0;
            5'h12: return 1;
            5'h13: return 2;
            5'h17: return 3;
            5'h1B: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_reg(input logic [4:0] m, input int i);
        int s = slot_of(m);
        if (i < 8)       return m_lo[i];
        else if (i < 13) return (m == 5'h11) ? m_hi_f[i-8] : m_hi_n[i-8];
        else if (i < 15) return m_sl[s + 1][i-13];
        else             return m_pc;
    endfunction

    function automatic logic [31:0] exp_spsr(input logic [4:0] m);
        int s = slot_of(m);
        return (s < 0) ? 32'h0 : m_spsr[s];
    endfunction

    function automatic string tag_of(input int i);
        if (i < 8)       return "R1";
        else if (i < 13) return "R2";
        else if (i < 15) return "R3";
        else             return "R4";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic model_write(input logic [4:0] m, input int i, input logic [31:0] v);
        int s = slot_of(m);
        if (i < 8)       m_lo[i] = v;
        else if (i < 13) begin
            if (m == 5'h11) m_hi_f[i-8] = v; else m_hi_n[i-8] = v;
        end
        else if (i < 15) m_sl[s + 1][i-13] = v;
        else             m_pc = v;
    endtask

    // Drive at negedge, commit at posedge, return at next negedge.
    task automatic set_mode(input logic [4:0] m);
        cpsr_wr_en = 1'b1; cpsr_wr_data = {27'h0, m};
        @(posedge clk); #1;
        cpsr_wr_en = 1'b0;
        m_mode = m;
        @(negedge clk);
    endtask

    task automatic write_reg(input int i, input logic [31:0] v);
        wr_en = 1'b1; wr_idx = 4'(i); wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(m_mode, i, v);
        @(negedge clk);
    endtask

    task automatic write_spsr(input logic [31:0] v);
        int s = slot_of(m_mode);
        spsr_wr_en = 1'b1; spsr_wr_data = v;
        @(posedge clk); #1;
        spsr_wr_en = 1'b0;
        if (s >= 0) m_spsr[s] = v;
        @(negedge clk);
    endtask

    task automatic sweep_mode(input logic [4:0] m);
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(15 - i);
            #1;
            check(tag_of(i), "port A read", rd_a_data, exp_reg(m, i));
            check(tag_of(15 - i), "port B read", rd_b_data, exp_reg(m, 15 - i));
        end
        check("R5", "saved status", spsr_q, exp_spsr(m));
        check("R6", "privileged", {31'h0, privileged}, {31'h0, m != 5'h10});
        check("R7", "exception mode", {31'h0, exc_mode}, {31'h0, (m != 5'h10) && (m != 5'h1F)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_lo[i] = '0;
        for (int i = 0; i < 5; i++) begin m_hi_n[i] = '0; m_hi_f[i] = '0; m_spsr[i] = '0; end
        for (int i = 0; i < 6; i++) begin m_sl[i][0] = '0; m_sl[i][1] = '0; end
        m_pc = '0;
        m_mode = 5'h13;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset contents and supervisor mode
        check("R10", "status after reset", cpsr_q, 32'h13);
        for (int i = 0; i < 16; i++) begin
            rd_a_idx = 4'(i); rd_b_idx = 4'(i);
            #1;
            check("R10", "register A after reset", rd_a_data, 32'h0);
            check("R10", "register B after reset", rd_b_data, 32'h0);
        end
        check("R10", "saved status after reset", spsr_q, 32'h0);

        // R8: same-cycle read returns old value, new value after the edge
        rd_a_idx = 4'd3; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hDEAD_0003;
        #1;
        check("R8", "read during write", rd_a_data, 32'h0);
        @(posedge clk); #1;
        wr_en = 1'b0;
        model_write(m_mode, 3, 32'hDEAD_0003);
        check("R8", "read after write", rd_a_data, 32'hDEAD_0003);
        @(negedge clk);

        // R9: register write in the same cycle as a mode change uses the old mode
        cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h11;
        wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h5A5A_0009;
        rd_a_idx = 4'd9;
        #1;
        check("R9", "mode before edge", cpsr_q, 32'h13);
        @(posedge clk); #1;
        cpsr_wr_en = 1'b0; wr_en = 1'b0;
        model_write(5'h13, 9, 32'h5A5A_0009);
        m_mode = 5'h11;
        check("R9", "fast copy untouched after mode change", rd_a_data, 32'h0);
        @(negedge clk);
        set_mode(5'h13);
        rd_a_idx = 4'd9; #1;
        check("R9", "normal copy took write", rd_a_data, 32'h5A5A_0009);

        // Fill every register and saved status in every mode
        foreach (modes[k]) begin
            set_mode(modes[k]);
            for (int i = 0; i < 16; i++)
                write_reg(i, {3'(k), modes[k], 4'(i), 20'hA5C3 + 20'(i * 7)});
            write_spsr({8'h5F, 3'(k), modes[k], 16'h1234});
            check("R5", "saved status after write", spsr_q, exp_spsr(modes[k]));
        end

        // Read back every register in every mode
        foreach (modes[k]) begin
            set_mode(modes[k]);
            sweep_mode(modes[k]);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule